// File: doc/BRIEF.md
# Dual-Clock Word Queue

This block is a first-in first-out word queue that joins two unrelated clock domains. A producer pushes words on its own clock, and a consumer pops them on another clock. Words leave in the order they arrived. Storage is a register array of 2^AW entries, each DW bits wide. Neither side gives an address. Each side keeps its own position counter, and that counter steps by one on every accepted access.

Each side's counter is AW+1 bits wide. The top bit records which lap around the array the counter is on. Every counter is also kept in Gray form and passed to the other clock through two flip-flops. The receiving side turns it back into binary and compares it with its own binary counter. From that comparison it raises `full` (producer side) or `empty` (consumer side).

Because of the synchronizer delay, a flag may stay raised for a few cycles after the queue has room again or holds data again. A flag is never cleared too early. The head word is shown on `rdData` whenever `empty` is low, and a pop moves on to the next word.

Top module: `dual_clock_queue`

## Requirements
- R1: While either reset is held low and directly after it is released, `empty` reads 1 and `full` reads 0.
- R2: Words popped come out in exactly the order they were pushed, and `rdData` shows the oldest unread word whenever `empty` is 0.
- R3: A push while `full` is 1 is ignored: that word is never delivered, and the stored words are unchanged.
- R4: A pop while `empty` is 1 is ignored: the read position does not move, so the next word pushed is the next word delivered.
- R5: `full` goes to 1 on the write-clock edge that makes the number of stored words 2^AW. That is when the two positions differ in their top bit and match in their lower AW bits. `full` rises only as a result of a push.
- R6: `empty` is 1 when the two positions are equal in all AW+1 bits, and it rises only as a result of a pop.
- R7: Positions wrap around the array with the top bit toggling on each lap, so fill, drain and refill behave the same from any starting position.
- R8: Flags clear late, never early. Right after a push into an empty queue, `empty` is still 1 until two read-clock edges have passed. Right after a pop from a full queue, `full` is still 1 until two write-clock edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Producer clock |
| wrRstN | input | 1 | Producer-side asynchronous reset, active low |
| wrEn | input | 1 | Push request |
| wrData | input | DW | Word to push |
| full | output | 1 | No room; pushes are ignored |
| rdClk | input | 1 | Consumer clock |
| rdRstN | input | 1 | Consumer-side asynchronous reset, active low |
| rdEn | input | 1 | Pop request |
| rdData | output | DW | Oldest unread word |
| empty | output | 1 | Nothing stored; pops are ignored |

## Verification
The properties assume that both resets are asserted together at start-up. They also assume that `wrEn` and `rdEn` change only away from their own clock's rising edge, so that each request is seen cleanly on one edge.

The bench drives each request on the falling edge of its own clock. It uses write and read clocks of unrelated periods, 8 ns and 11 ns. Before any flag is compared with its settled value, the bench waits at least four edges of both clocks. The only exceptions are the checks for late clearing, which sample right after a single access.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  // Access strobes passed from control to the storage array
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } dcqStrobe_t;
endpackage

// File: rtl/dcq_sync.sv
// Carries a Gray-coded position into the local clock through two flops
// and returns it in binary.
module dcq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  // binary bit i is the XOR of all Gray bits from i up to the top
  for (genvar i = 0; i < W; i++) begin : g_toBin
    assign binOut[i] = ^(stage2 >> i);
  end
endmodule

// File: rtl/dcq_store.sv
// Storage array: written on the producer clock, read without a clock.
module dcq_store #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic               wrClk,
  input  dcq_pkg::dcqStrobe_t strobes,
  input  logic [AW-1:0]      wrAddr,
  input  logic [DW-1:0]      wrData,
  input  logic [AW-1:0]      rdAddr,
  output logic [DW-1:0]      rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrFire) cells[wrAddr] <= wrData;
  end

  assign rdData = cells[rdAddr];
endmodule

// File: rtl/dcq_ctrl.sv
// Position counters, Gray copies, crossings and flag logic for both sides.
module dcq_ctrl #(
  parameter int AW = 3
) (
  input  logic                wrClk,
  input  logic                wrRstN,
  input  logic                wrEn,
  input  logic                rdClk,
  input  logic                rdRstN,
  input  logic                rdEn,
  output logic                full,
  output logic                empty,
  output dcq_pkg::dcqStrobe_t strobes,
  output logic [AW-1:0]       wrAddr,
  output logic [AW-1:0]       rdAddr
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wBin, wBinNext, wGray, rSeenBin;
  logic [PW-1:0] rBin, rBinNext, rGray, wSeenBin;

  // producer side
  assign strobes.wrFire = wrEn & ~full;
  assign wBinNext = wBin + PW'(strobes.wrFire);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else begin
      wBin  <= wBinNext;
      wGray <= wBinNext ^ (wBinNext >> 1);
    end
  end

  dcq_sync #(.W(PW)) u_rdToWr (
    .clk(wrClk), .rstN(wrRstN), .grayIn(rGray), .binOut(rSeenBin)
  );

  assign full = (wBin[AW] != rSeenBin[AW]) && (wBin[AW-1:0] == rSeenBin[AW-1:0]);

  // consumer side
  assign strobes.rdFire = rdEn & ~empty;
  assign rBinNext = rBin + PW'(strobes.rdFire);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rBin  <= '0;
      rGray <= '0;
    end else begin
      rBin  <= rBinNext;
      rGray <= rBinNext ^ (rBinNext >> 1);
    end
  end

  dcq_sync #(.W(PW)) u_wrToRd (
    .clk(rdClk), .rstN(rdRstN), .grayIn(wGray), .binOut(wSeenBin)
  );

  assign empty = (rBin == wSeenBin);

  assign wrAddr = wBin[AW-1:0];
  assign rdAddr = rBin[AW-1:0];
endmodule

// File: rtl/dual_clock_queue.sv
module dual_clock_queue #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic          full,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          empty
);
  dcq_pkg::dcqStrobe_t strobes;
  logic [AW-1:0] wrAddr, rdAddr;

  dcq_ctrl #(.AW(AW)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .full(full), .empty(empty), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  dcq_store #(.DW(DW), .AW(AW)) u_store (
    .wrClk(wrClk), .strobes(strobes), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/dcq_checker.sv
module dcq_checker #(
  parameter int AW = 3
) (
  input logic                wrClk,
  input logic                wrRstN,
  input logic                rdClk,
  input logic                rdRstN,
  input logic                full,
  input logic                empty,
  input dcq_pkg::dcqStrobe_t strobes,
  input logic [AW-1:0]       wrAddr,
  input logic [AW-1:0]       rdAddr
);
  assert_no_overflow_R3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    full |-> !strobes.wrFire);

  assert_no_underflow_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    empty |-> !strobes.rdFire);

  assert_wr_step_R7: assert property (@(posedge wrClk) disable iff (!wrRstN)
    strobes.wrFire |=> wrAddr == AW'($past(wrAddr) + 1'b1));

  assert_wr_hold_R3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !strobes.wrFire |=> $stable(wrAddr));

  assert_rd_step_R7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    strobes.rdFire |=> rdAddr == AW'($past(rdAddr) + 1'b1));

  assert_rd_hold_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !strobes.rdFire |=> $stable(rdAddr));

  assert_full_by_push_R5: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $rose(full) |-> $past(strobes.wrFire));

  assert_empty_by_pop_R6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $rose(empty) |-> $past(strobes.rdFire));
endmodule

bind dual_clock_queue dcq_checker #(.AW(AW)) u_checker (
  .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
  .full(full), .empty(empty), .strobes(strobes),
  .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/dual_clock_queue_test.sv
`timescale 1ns/1ps
module dual_clock_queue_test;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wrClk = 0, rdClk = 0;
  logic wrRstN = 0, rdRstN = 0;
  logic wrEn = 0, rdEn = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic full, empty;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 wrClk = ~wrClk;    // 125 MHz
  always #5.5 rdClk = ~rdClk;

  dual_clock_queue #(.DW(DW), .AW(AW)) uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .full(full),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData), .empty(empty)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
  endtask

  task automatic push(logic [DW-1:0] d);
    @(negedge wrClk);
    wrEn = 1; wrData = d;
    @(negedge wrClk);
    wrEn = 0;
  endtask

  task automatic popCheck(string tag, logic [DW-1:0] exp);
    @(negedge rdClk);
    check(tag, rdData, exp);
    rdEn = 1;
    @(negedge rdClk);
    rdEn = 0;
  endtask

  task automatic testReset();
    #1;
    check("R1 empty in reset", empty, 1);
    check("R1 full in reset", full, 0);
    #20; wrRstN = 1; rdRstN = 1;
    settle();
    check("R1 empty after reset", empty, 1);
    check("R1 full after reset", full, 0);
  endtask

  task automatic testOrder();
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    settle();
    check("R6 not empty with data", empty, 0);
    for (int i = 0; i < 5; i++) popCheck("R2 order", 8'h10 + 8'(i));
    settle();
    check("R6 empty after drain", empty, 1);
  endtask

  task automatic testOverflow();
    for (int i = 0; i < DEPTH; i++) push(8'h30 + 8'(i));
    #1;
    check("R5 full on last push", full, 1);
    settle();
    check("R5 full held", full, 1);
    push(8'hEE);
    settle();
    check("R3 still full", full, 1);
    for (int i = 0; i < DEPTH; i++) popCheck("R3 stored words intact", 8'h30 + 8'(i));
    settle();
    check("R3 extra word not stored", empty, 1);
    check("R5 full cleared", full, 0);
  endtask

  task automatic testUnderflow();
    @(negedge rdClk); rdEn = 1;
    repeat (3) @(negedge rdClk);
    rdEn = 0;
    check("R4 empty stays", empty, 1);
    push(8'h5A);
    settle();
    check("R4 not empty", empty, 0);
    popCheck("R4 next word", 8'h5A);
    settle();
    check("R4 empty after single pop", empty, 1);
  endtask

  task automatic testWrap();
    for (int lap = 0; lap < 2; lap++) begin
      for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(lap * 16 + i));
      settle();
      check("R7 full each lap", full, 1);
      for (int i = 0; i < DEPTH; i++) popCheck("R7 data across wrap", 8'h80 + 8'(lap * 16 + i));
      settle();
      check("R7 empty each lap", empty, 1);
    end
  endtask

  task automatic testLateClear();
    push(8'hC3);
    check("R8 empty still set right after push", empty, 1);
    settle();
    check("R8 empty cleared later", empty, 0);
    for (int i = 1; i < DEPTH; i++) push(8'hC3 + 8'(i));
    #1;
    check("R5 full at depth", full, 1);
    settle();
    popCheck("R8 head word", 8'hC3);
    check("R8 full still set right after pop", full, 1);
    settle();
    check("R8 full cleared later", full, 0);
    for (int i = 1; i < DEPTH; i++) popCheck("R2 remaining words", 8'hC3 + 8'(i));
    settle();
    check("R6 empty at end", empty, 1);
  endtask

  initial begin
    testReset();
    testOrder();
    testOverflow();
    testUnderflow();
    testWrap();
    testLateClear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule